// File: doc/BRIEF.md
# Repeated-Subtraction Reduction Unit

This block reduces an unsigned operand by another through repeated subtraction. It runs "while a > b, a = a - b" and returns the value of a once the condition no longer holds. For a strictly greater than a non-zero b, the result lies in the range 1 to b. When a is not greater than b, a is returned unchanged.

A single adder/subtractor does both jobs. It decides the loop condition from its own carry-out and non-zero result, and it produces the updated operand. A three-state controller alternates the two uses, so every pass through the loop costs two clock cycles.

A job begins with a one-cycle start pulse that carries both operands. A start pulse that arrives while a job is running is dropped. A divisor of zero with a non-zero dividend would never terminate, so the block rejects it at once and raises an error flag.

Top module: `rsub_reduce`

## Requirements
- R1: While rst_n is low, and after reset until the first job, result_o is 0, done_o is 0 and err_o is 0.
- R2: For a job with b_i non-zero, result_o equals the value that remains after repeatedly replacing a with a - b while a > b (unsigned). Each update subtracts exactly the held b from the held a.
- R3: The comparison is strict. When a equals b, or a is less than b, result_o equals a_i and no subtraction takes place.
- R4: The loop condition is taken from the shared adder, which forms a + ~b + 1. The condition is true only when the carry-out is 1 and the WIDTH-bit difference is non-zero, and it is cleared at every accepted start.
- R5: Let k be the number of subtractions a job performs. Counting the rising edge that samples start_i as edge 1, done_o is first high after edge 2k+3.
- R6: done_o is high for exactly one cycle per job, in the same cycle as the new result_o.
- R7: If start_i is high with b_i == 0 and a_i != 0, done_o and err_o are high after edge 1, and result_o equals a_i.
- R8: A job with a_i == 0 and b_i == 0 is not an error. It gives result_o == 0 and err_o == 0, with done_o after edge 3.
- R9: start_i has no effect while a job is in progress. The operands of the running job are kept, and its result and timing are unchanged.
- R10: result_o and err_o keep their values between jobs. err_o returns to 0 at the end of the next job that is not an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| start_i | input | 1 | One-cycle request that samples a_i and b_i |
| a_i | input | WIDTH | Unsigned operand that is reduced |
| b_i | input | WIDTH | Unsigned amount subtracted on each pass |
| result_o | output | WIDTH | Final value of a, held until the next job ends |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| err_o | output | 1 | High when the last job had b zero and a non-zero |

## Verification
The bench builds the unit with WIDTH set to 8. This puts the longest possible job (a = 255, b = 1, 254 subtractions) in reach within a few hundred cycles. It also places the carry-out boundary, with operands at and near the top of the range, in the vector table. Each job's expected result and pass count come from the loop definition. Every vector is checked for both value and exact latency, so a wrong comparison, an extra or missing pass, or a lost pipeline step appears as a mismatch.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_STEP = 2'd2
  } rsub_state_e;

endpackage

// File: rtl/rsub_rst_sync.sv
module rsub_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsub_addsub.sv
module rsub_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] lhs_i,
  input  logic [WIDTH-1:0] rhs_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             gt_o
);

  localparam int SUMW = WIDTH + 1;

  logic [SUMW-1:0] total;
  logic            carry;

  // lhs + (~rhs) + 1 : two's-complement subtraction through one adder
  assign total  = {1'b0, lhs_i} + {1'b0, ~rhs_i} + SUMW'(1);
  assign diff_o = total[WIDTH-1:0];
  assign carry  = total[WIDTH];
  // carry set means no borrow (lhs >= rhs); non-zero rules out equality
  assign gt_o   = carry & (|diff_o);

endmodule

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
  import rsub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_div_i,
  input  logic flag_i,
  output logic busy_o,
  output logic ld_ops_o,
  output logic ld_flag_o,
  output logic ld_a_o,
  output logic ld_res_o,
  output logic res_src_o,
  output logic err_set_o,
  output logic done_set_o
);

  rsub_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    ld_ops_o   = 1'b0;
    ld_flag_o  = 1'b0;
    ld_a_o     = 1'b0;
    ld_res_o   = 1'b0;
    res_src_o  = 1'b0;
    err_set_o  = 1'b0;
    done_set_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (zero_div_i) begin
            ld_res_o   = 1'b1;
            res_src_o  = 1'b1;
            err_set_o  = 1'b1;
            done_set_o = 1'b1;
          end else begin
            ld_ops_o = 1'b1;
            state_d  = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        ld_flag_o = 1'b1;
        state_d   = ST_STEP;
      end
      ST_STEP: begin
        if (flag_i) begin
          ld_a_o  = 1'b1;
          state_d = ST_EVAL;
        end else begin
          ld_res_o   = 1'b1;
          done_set_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);

  AST_EVAL_THEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) |=> (state_q == ST_STEP)); // R5

  AST_STEP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP) |=> (state_q != ST_STEP)); // R5

endmodule

// File: rtl/rsub_reduce.sv
module rsub_reduce
  import rsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int SYNC_STAGES = 2;

  logic             rst_int_n;
  logic [WIDTH-1:0] a_q, b_q, res_q, diff;
  logic             flag_q, gt, err_q, done_q;
  logic             zero_div, busy;
  logic             ld_ops, ld_flag, ld_a, ld_res, res_src, err_set, done_set;

  rsub_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  rsub_addsub #(.WIDTH(WIDTH)) u_addsub (
    .lhs_i  (a_q),
    .rhs_i  (b_q),
    .diff_o (diff),
    .gt_o   (gt)
  );

  assign zero_div = (b_i == '0) && (a_i != '0);

  rsub_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .zero_div_i (zero_div),
    .flag_i     (flag_q),
    .busy_o     (busy),
    .ld_ops_o   (ld_ops),
    .ld_flag_o  (ld_flag),
    .ld_a_o     (ld_a),
    .ld_res_o   (ld_res),
    .res_src_o  (res_src),
    .err_set_o  (err_set),
    .done_set_o (done_set)
  );

  // operand register a: loaded from the port or from the shared adder
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  a_q <= '0;
    else if (ld_ops) a_q <= a_i;
    else if (ld_a)   a_q <= diff;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  b_q <= '0;
    else if (ld_ops) b_q <= b_i;
  end

  // loop condition flag, forced false at each accepted start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   flag_q <= 1'b0;
    else if (ld_ops)  flag_q <= 1'b0;
    else if (ld_flag) flag_q <= gt;
  end

  // final-result register fed through the exit-side route
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (ld_res) begin
      res_q <= res_src ? a_i : a_q;
      err_q <= err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= done_set;
  end

  assign result_o = res_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  AST_FLAG_IS_GT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_flag |=> (flag_q == ($past(a_q) > $past(b_q)))); // R4

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_ops |=> !flag_q); // R4

  AST_SUB_EXACT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_a |=> (a_q == $past(a_q) - $past(b_q))); // R2

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !err_o && (b_q != '0)) |-> (result_o <= b_q)); // R2

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && err_o) |-> ($past(start_i) && ($past(b_i) == '0))); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done_o |-> ($stable(result_o) && $stable(err_o))); // R10

  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> ($stable(b_q) || !busy)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !err_o) |=> (!done_o || err_o)); // R6

endmodule

// File: tb/rsub_reduce_tb.sv
`timescale 1ns/1ps
module rsub_reduce_tb;

  localparam int W = 8;
  localparam int NV = 10;
  // columns: a, b, expected result, expected number of subtractions
  localparam int VEC [NV][4] = '{
    '{100,   7,   2, 14},
    '{ 21,   7,   7,  2},
    '{  7,   7,   7,  0},
    '{  3,   9,   3,  0},
    '{255,   1,   1, 254},
    '{200,  50,  50,  3},
    '{  0,   5,   0,  0},
    '{250, 251, 250,  0},
    '{129, 128,   1,  1},
    '{255, 255, 255,  0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] result_o;
  logic         done_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rsub_reduce #(.WIDTH(W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one job and wait for done; lat counts rising edges from the sampling edge
  task automatic run_op(input int a, input int b, output int res, output int lat, output int errv);
    @(negedge clk);
    a_i = W'(a); b_i = W'(b); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    res = int'(result_o);
    errv = int'(err_o);
  endtask

  task automatic check_pulse_end(input string req);
    @(negedge clk);
    check(!done_o, req, int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int res, lat, errv;
    rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check(result_o == 0, "R1 result", int'(result_o), 0);
    check(!done_o, "R1 done", int'(done_o), 0);
    check(!err_o, "R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(result_o == 0 && !done_o && !err_o, "R1 after release", int'(result_o), 0);

    // vector table: R2, R3, R5, R6
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][0], VEC[i][1], res, lat, errv);
      check(res == VEC[i][2], "R2 R3 result", res, VEC[i][2]);
      check(lat == 2 * VEC[i][3] + 3, "R5 latency", lat, 2 * VEC[i][3] + 3);
      check(errv == 0, "R2 no error", errv, 0);
      check_pulse_end("R6 single pulse");
    end

    // R7: zero b, non-zero a
    run_op(37, 0, res, lat, errv);
    check(res == 37, "R7 result", res, 37);
    check(errv == 1, "R7 err", errv, 1);
    check(lat == 1, "R7 latency", lat, 1);
    check_pulse_end("R6 error pulse");
    // R10: err and result held between jobs
    repeat (5) @(negedge clk);
    check(err_o && result_o == 37, "R10 held after error", int'(result_o), 37);

    // R10: err clears on next good job (10 -> 7 -> 4 -> 1)
    run_op(10, 3, res, lat, errv);
    check(res == 1, "R10 result", res, 1);
    check(errv == 0, "R10 err cleared", errv, 0);
    check(lat == 9, "R5 latency k3", lat, 9);

    // R8: zero over zero
    run_op(0, 0, res, lat, errv);
    check(res == 0, "R8 result", res, 0);
    check(errv == 0, "R8 err", errv, 0);
    check(lat == 3, "R8 latency", lat, 3);

    // R9: start while busy is dropped
    @(negedge clk);
    a_i = 8'd100; b_i = 8'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    a_i = 8'd5; b_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; a_i = 8'd9; b_i = 8'd2;
    lat = 5;
    while (!done_o && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    check(result_o == 2, "R9 result kept", int'(result_o), 2);
    check(!err_o, "R9 no error", int'(err_o), 0);
    check(lat == 31, "R9 latency kept", lat, 31);
    check_pulse_end("R6 pulse after R9");
    repeat (6) @(negedge clk);
    check(result_o == 2 && !done_o, "R10 result held", int'(result_o), 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule